// File: doc/BRIEF.md
# Discharge Overload Guard

This block sequences the response of a battery pack to a sustained discharge overload. An external comparator reports, one bit wide and already registered, whether the discharge current is above a threshold. The block hands that comparator its 4-bit threshold code. Once the overload has persisted for a programmed number of millisecond ticks, the block switches off the discharge and charge FET enables. It re-enables them after a programmed recovery time.

Every trip also advances a small saturating latch counter. The counter decays by one for each programmed quiet period during which the overload stays low. When permanent fail is enabled and the counter reaches a nonzero limit, a sticky permanent-fail output holds both FETs off until reset. A 1 ms tick input paces every timer. The recovery time and the decay time are given in whole seconds of 1000 ticks each.

Top module: `ovl_dsg_guard`

## Requirements
- R1: After reset both FET enables are 1, `alert_o`, `trip_o` and `pf_o` are 0, and `latch_cnt_o` is 0.
- R2: The trip delay code is `cfg_i[7:4]`. A trip happens on the clock edge that carries the (2*code+1)-th consecutive ticked cycle with `ovl_i` high while the FETs are enabled, so the longest delay is 31 ticks.
- R3: After a trip edge, `dsg_en_o` and `chg_en_o` are both 0, and `alert_o` and `trip_o` are both 1.
- R4: If `ovl_i` falls before the delay completes, the delay count restarts from zero and no trip occurs.
- R5: The latch counter rises by one on every trip and saturates at 15.
- R6: While `ovl_i` is low and the counter is nonzero, the counter falls by one after each `decay_s_i`*1000 ticks. A high `ovl_i` restarts that window.
- R7: A trip that leaves the counter at or above a nonzero `latch_lim_i` while `pf_en_i` is 1 sets `pf_o`. Only reset clears `pf_o`, and while it is set both FET enables stay 0.
- R8: After a trip, without permanent fail, both FET enables return to 1 and `alert_o` clears on the edge that carries the `recov_s_i`*1000-th tick after the trip edge. A value of 0 means the first tick after the trip. `trip_o` stays set until reset.
- R9: With `latch_lim_i` equal to 0 or `pf_en_i` equal to 0, `pf_o` never sets, but every trip still cuts both FETs.
- R10: `thr_code_o` always equals `cfg_i[3:0]`.
- R11: No timer advances in a cycle where `tick_i` is 0. A trip or a recovery happens only on an edge where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms timebase strobe, one cycle wide |
| ovl_i | input | 1 | Registered overload comparator result |
| cfg_i | input | 8 | Delay code [7:4] and threshold code [3:0] |
| latch_lim_i | input | 4 | Trip count for permanent fail; 0 disables escalation |
| pf_en_i | input | 1 | Permits escalation to permanent fail |
| recov_s_i | input | SEC_W | Recovery time in seconds |
| decay_s_i | input | SEC_W | Counter decay window in seconds |
| dsg_en_o | output | 1 | Discharge FET enable |
| chg_en_o | output | 1 | Charge FET enable |
| alert_o | output | 1 | Set on trip, cleared at recovery |
| trip_o | output | 1 | Sticky trip indication |
| pf_o | output | 1 | Sticky permanent fail |
| latch_cnt_o | output | 4 | Latch counter value |
| thr_code_o | output | 4 | Threshold code for the comparator |

## Verification
Every registered result appears one cycle after the edge that samples its cause. The FET cut and the flags follow the (2*code+1)-th ticked overload edge. Re-enable follows the recovery-length tick count after the trip edge, and a decrement follows each full decay window. The bench drives inputs on the falling edge and then samples at the falling edge after the edge it has counted. The directed checks therefore read outputs one edge before and exactly at each expected change. In the random phase, a bench model of the requirements advances on the same edges and is compared in every cycle.

// File: rtl/ovg_pkg.sv
package ovg_pkg;
    localparam int LCNT_W = 4;
    localparam logic [LCNT_W-1:0] LCNT_MAX = '1;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_OFF   = 1'b1
    } ovg_state_e;

    typedef struct packed {
        ovg_state_e state;
        logic       alert;
        logic       trip;
    } ovg_ctl_t;

    typedef struct packed {
        logic [LCNT_W-1:0] cnt;
        logic              pf;
    } ovg_lat_t;
endpackage

// File: rtl/ovg_window.sv
// Tick-paced window counter: counts ticks while run is high and pulses done
// on the tick that completes limit ticks, then starts over.
module ovg_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        cnt_d = cnt_q;
        done  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (nxt >= {1'b0, limit}) begin
                done  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = nxt[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: a count only moves upward when a tick was present.
    assert_adv_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q != $past(cnt_q)) && (cnt_q != '0)) |-> $past(tick));
endmodule

// File: rtl/ovg_latch.sv
// Saturating trip counter with sticky escalation flag.
module ovg_latch import ovg_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              pf_en,
    input  logic [LCNT_W-1:0] lim,
    output logic [LCNT_W-1:0] cnt,
    output logic              pf
);
    ovg_lat_t          st_d, st_q;
    logic [LCNT_W-1:0] bumped;

    always_comb begin
        st_d   = st_q;
        bumped = (st_q.cnt == LCNT_MAX) ? st_q.cnt : st_q.cnt + LCNT_W'(1);
        if (inc) begin
            st_d.cnt = bumped;
            if (pf_en && (lim != '0) && (bumped >= lim)) st_d.pf = 1'b1;
        end else if (dec && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - LCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign pf  = st_q.pf;

    assert_pf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pf |=> st_q.pf);
    assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt == LCNT_MAX) && inc) |=> (st_q.cnt == LCNT_MAX));
    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + LCNT_W'(1))
        || (st_q.cnt == $past(st_q.cnt) - LCNT_W'(1)));
    assert_pf_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pf) |-> ($past(pf_en) && ($past(lim) != '0)));
endmodule

// File: rtl/ovl_dsg_guard.sv
// Discharge overload guard: trip delay, FET cut, timed recovery, latch
// counter with quiet-period decay and permanent-fail escalation.
module ovl_dsg_guard import ovg_pkg::*; #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ovl_i,
    input  logic [7:0]        cfg_i,
    input  logic [LCNT_W-1:0] latch_lim_i,
    input  logic              pf_en_i,
    input  logic [SEC_W-1:0]  recov_s_i,
    input  logic [SEC_W-1:0]  decay_s_i,
    output logic              dsg_en_o,
    output logic              chg_en_o,
    output logic              alert_o,
    output logic              trip_o,
    output logic              pf_o,
    output logic [LCNT_W-1:0] latch_cnt_o,
    output logic [3:0]        thr_code_o
);
    localparam int DLY_W  = 5;
    localparam int LONG_W = $clog2(((1 << SEC_W) - 1) * TICKS_PER_SEC + 1);

    ovg_ctl_t          st_d, st_q;
    logic [DLY_W-1:0]  dly_lim;
    logic [LONG_W-1:0] rec_lim, dec_lim;
    logic              dly_run, rec_run, dec_run;
    logic              trip_now, rec_done, dec_done;

    // delay code c gives 2*c+1 ticks
    assign dly_lim = {cfg_i[7:4], 1'b1};
    assign rec_lim = LONG_W'(recov_s_i) * LONG_W'(TICKS_PER_SEC);
    assign dec_lim = LONG_W'(decay_s_i) * LONG_W'(TICKS_PER_SEC);

    assign dly_run = (st_q.state == ST_ARMED) && ovl_i;
    assign rec_run = (st_q.state == ST_OFF) && !pf_o;
    assign dec_run = !ovl_i && (latch_cnt_o != '0);

    ovg_window #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .run(dly_run), .tick(tick_i),
        .limit(dly_lim), .done(trip_now));

    ovg_window #(.W(LONG_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .run(rec_run), .tick(tick_i),
        .limit(rec_lim), .done(rec_done));

    ovg_window #(.W(LONG_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .run(dec_run), .tick(tick_i),
        .limit(dec_lim), .done(dec_done));

    ovg_latch u_lat (
        .clk(clk), .rst_n(rst_n), .inc(trip_now), .dec(dec_done),
        .pf_en(pf_en_i), .lim(latch_lim_i), .cnt(latch_cnt_o), .pf(pf_o));

    always_comb begin
        st_d = st_q;
        if (trip_now) begin
            st_d.state = ST_OFF;
            st_d.alert = 1'b1;
            st_d.trip  = 1'b1;
        end else if (rec_done) begin
            st_d.state = ST_ARMED;
            st_d.alert = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_ARMED, alert: 1'b0, trip: 1'b0};
        else        st_q <= st_d;
    end

    assign dsg_en_o   = (st_q.state == ST_ARMED);
    assign chg_en_o   = (st_q.state == ST_ARMED);
    assign alert_o    = st_q.alert;
    assign trip_o     = st_q.trip;
    assign thr_code_o = cfg_i[3:0];

    assert_cut_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_en_o) |-> (alert_o && trip_o && !chg_en_o));
    assert_cut_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_en_o) |-> ($past(ovl_i) && $past(tick_i)));
    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsg_en_o) |-> (!alert_o && !pf_o && $past(tick_i)));
    assert_pf_holds_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_o |-> (!dsg_en_o && !chg_en_o));
endmodule

// File: tb/ovl_dsg_guard_bench.sv
`timescale 1ns/1ps
module ovl_dsg_guard_bench;
    localparam int TPS = 1000;
    localparam int SW  = 4;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ovl = 1'b0, pf_en = 1'b0;
    logic [7:0]    cfg = '0;
    logic [3:0]    lim = '0;
    logic [SW-1:0] recov = '0, decay = '0;
    logic          dsg, chg, alert, trip, pf;
    logic [3:0]    lcnt, thr;
    int            checks = 0, errors = 0;

    always #5 clk = ~clk;

    ovl_dsg_guard #(.TICKS_PER_SEC(TPS), .SEC_W(SW)) u_ovl_dsg_guard (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ovl_i(ovl), .cfg_i(cfg),
        .latch_lim_i(lim), .pf_en_i(pf_en), .recov_s_i(recov), .decay_s_i(decay),
        .dsg_en_o(dsg), .chg_en_o(chg), .alert_o(alert), .trip_o(trip),
        .pf_o(pf), .latch_cnt_o(lcnt), .thr_code_o(thr));

    // Reference model written from the requirements.
    logic       m_off, m_alert, m_trip, m_pf;
    logic [3:0] m_lc;
    int         m_d, m_r, m_k;

    always @(posedge clk or negedge rst_n) begin : mdl
        int dl, rl, kl;
        bit tr, rd, kd;
        logic [3:0] nl;
        if (!rst_n) begin
            m_off <= 0; m_alert <= 0; m_trip <= 0; m_pf <= 0; m_lc <= 0;
            m_d <= 0; m_r <= 0; m_k <= 0;
        end else begin
            dl = 2 * cfg[7:4] + 1; rl = recov * TPS; kl = decay * TPS;
            tr = 0; rd = 0; kd = 0;
            if (!m_off && ovl) begin
                if (tick) begin
                    if (m_d + 1 >= dl) begin tr = 1; m_d <= 0; end else m_d <= m_d + 1;
                end
            end else m_d <= 0;
            if (m_off && !m_pf) begin
                if (tick) begin
                    if (m_r + 1 >= rl) begin rd = 1; m_r <= 0; end else m_r <= m_r + 1;
                end
            end else m_r <= 0;
            if (!ovl && m_lc != 0) begin
                if (tick) begin
                    if (m_k + 1 >= kl) begin kd = 1; m_k <= 0; end else m_k <= m_k + 1;
                end
            end else m_k <= 0;
            nl = m_lc;
            if (tr) begin
                nl = (m_lc == 4'd15) ? 4'd15 : m_lc + 4'd1;
                if (pf_en && lim != 0 && nl >= lim) m_pf <= 1;
                m_off <= 1; m_alert <= 1; m_trip <= 1;
            end else begin
                if (kd) nl = m_lc - 4'd1;
                if (rd) begin m_off <= 0; m_alert <= 0; end
            end
            m_lc <= nl;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_dut();
        ovl = 0; rst_n = 0;
        step(2);
        rst_n = 1;
        step(1);
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state, R10 threshold passthrough
        cfg = 8'h5A;
        reset_dut();
        chk("R1 dsg", dsg, 1); chk("R1 chg", chg, 1); chk("R1 alert", alert, 0);
        chk("R1 trip", trip, 0); chk("R1 cnt", lcnt, 0); chk("R1 pf", pf, 0);
        chk("R10 thr", thr, 4'hA);

        // R2 delay code 3 -> 7 ticks, R3 cut, R8 recovery of 1 s
        reset_dut();
        cfg = 8'h3C; tick = 1; recov = 1; decay = 15; lim = 0; pf_en = 0; ovl = 1;
        step(6); chk("R2 no trip at 6 ticks", dsg, 1);
        step(1); chk("R3 dsg cut", dsg, 0); chk("R3 chg cut", chg, 0);
        chk("R3 alert", alert, 1); chk("R3 trip", trip, 1); chk("R5 cnt", lcnt, 1);
        ovl = 0;
        step(999); chk("R8 still off", dsg, 0); chk("R8 alert held", alert, 1);
        step(1); chk("R8 dsg on", dsg, 1); chk("R8 chg on", chg, 1);
        chk("R8 alert clear", alert, 0); chk("R8 trip sticky", trip, 1);

        // R4 glitch restarts delay
        reset_dut();
        cfg = 8'h30; tick = 1; ovl = 1;
        step(6); chk("R4 pre glitch", dsg, 1);
        ovl = 0; step(1); chk("R4 glitch", dsg, 1);
        ovl = 1; step(6); chk("R4 restarted", dsg, 1);
        step(1); chk("R4 full delay trips", dsg, 0);

        // R11 no progress without tick
        reset_dut();
        cfg = 8'h00; recov = 0; tick = 0; ovl = 1;
        step(40); chk("R11 no tick no trip", dsg, 1);
        tick = 1; step(1); chk("R11 tick trips", dsg, 0);
        tick = 0; step(20); chk("R11 no tick no recovery", dsg, 0);
        tick = 1; step(1); chk("R11 tick recovers", dsg, 1);
        ovl = 0;

        // R6 decay, two windows
        reset_dut();
        cfg = 8'h00; tick = 1; recov = 0; decay = 1; lim = 0; ovl = 1;
        step(3); chk("R5 two trips", lcnt, 2);
        ovl = 0;
        step(999); chk("R6 before window", lcnt, 2);
        step(1); chk("R6 first decrement", lcnt, 1);
        step(999); chk("R6 before second", lcnt, 1);
        step(1); chk("R6 second decrement", lcnt, 0);

        // R7 permanent fail at limit 2
        reset_dut();
        cfg = 8'h00; tick = 1; recov = 0; decay = 15; lim = 2; pf_en = 1; ovl = 1;
        step(2); chk("R7 pf not yet", pf, 0); chk("R7 rearmed", dsg, 1);
        step(1); chk("R7 pf set", pf, 1); chk("R7 cnt", lcnt, 2); chk("R7 dsg off", dsg, 0);
        ovl = 0;
        step(20); chk("R7 pf sticky", pf, 1); chk("R7 dsg held", dsg, 0);
        chk("R7 chg held", chg, 0);

        // R5 saturation, R9 limit zero
        reset_dut();
        cfg = 8'h00; tick = 1; recov = 0; decay = 15; lim = 0; pf_en = 1; ovl = 1;
        step(40); chk("R5 saturate", lcnt, 15); chk("R9 lim0 no pf", pf, 0);
        pf_en = 0; lim = 3;
        step(1); chk("R9 pf disabled", pf, 0); chk("R9 still cuts", dsg, 0);
        ovl = 0;

        // Random phase against the model
        for (int i = 0; i < 30000; i++) begin
            chk("R3 R5 R6 R7 R8 random", {dsg, chg, alert, trip, pf, lcnt},
                {~m_off, ~m_off, m_alert, m_trip, m_pf, m_lc});
            chk("R10 random", thr, cfg[3:0]);
            rst_n = (i % 3000 == 0) ? 1'b0 : 1'b1;
            if ($urandom % 8 == 0) ovl = ~ovl;
            tick = ($urandom % 8) != 0;
            if (i % 400 == 0) begin
                cfg = 8'($urandom); recov = SW'($urandom % 2); decay = SW'($urandom % 2);
                lim = 4'($urandom); pf_en = ($urandom % 4) == 0;
            end
            step(1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule